// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Flags

This block recovers characters from an asynchronous serial line. A single-cycle enable, `os_tick`, arrives at sixteen times the bit rate. The block uses it to find the falling edge of a start bit. It confirms the start bit at the middle of that bit and then samples every later bit at its centre. The frame shape comes from four configuration inputs: 5 to 8 data bits, an optional parity bit with even or odd sense, and one or two stop bits. The block captures these inputs when a start edge is seen, so each frame keeps the shape it began with.

For every character, the block presents the data byte on a one-cycle strobe, together with three flags for a status register: parity error, framing error and break. A break is a spacing level that lasts longer than one whole character. That length is start + data + parity + stop bits, measured in ticks for the frame's own configuration. A break produces exactly one all-zero character. After it, the receiver ignores the line until the line returns to mark. Baud-rate generation and processor register access are handled outside this block.

Top module: `serial_rx_core`

## Requirements
- R1: After synchronous reset, `rx_strobe`, `rx_data`, `rx_perr`, `rx_ferr` and `rx_break` are all 0.
- R2: A low pulse on `rxd` that has returned to 1 by the eighth tick after the falling edge is treated as a glitch and produces no strobe.
- R3: Data bits arrive LSB first. `cfg_len` 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. Received bits fill `rx_data` from bit 0 upward, and the unused upper bits read 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_even` = 1 the data plus parity must hold an even number of ones, and with 0 an odd number. `rx_perr` is 1 exactly when this rule is broken. When `cfg_par_en` is 0 there is no parity bit and `rx_perr` is 0.
- R5: If the first stop bit is sampled at 0, `rx_ferr` is 1. When no break follows, the character is reported once the line returns to 1, with its received data.
- R6: If the line stays at 0 for more than (1 + data bits + parity bit + stop bits) × 16 ticks, exactly one character is reported, with `rx_data` = 0, `rx_break` = 1 and `rx_ferr` = 1. No further start bit is accepted until the line has returned to 1. A low period of exactly that length is reported as a framing error without break.
- R7: The break threshold follows the current frame configuration. With 8 data bits and no parity, a low period of 11 bit times is a break with one stop bit and is not a break with two.
- R8: `rx_strobe` is high for one clock cycle per character. `rx_data` and all three flags are valid in that same cycle and hold until the next strobe.
- R9: Only clock cycles with `os_tick` high advance the receiver. At a tick rate of one every two clocks, a frame of bits 32 clocks long is received correctly.
- R10: With two stop bits selected, frames sent back to back without extra idle time are each received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code: 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rx_data | output | 8 | Received character, LSB aligned |
| rx_strobe | output | 1 | One-cycle character-complete pulse |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Stop bit was sampled as spacing |
| rx_break | output | 1 | Character was produced by a break |

## Verification
The assertions assume that `os_tick` is a one-cycle enable and that the configuration pins do not change between a falling edge and the capture that goes with it. They also assume that `rxd` only changes at whole bit boundaries of the tick grid, so the centre sample lands well inside each bit. The stimulus runs the tick either every cycle or every second cycle. It changes the configuration only while the line is idle. It holds each bit for exactly sixteen ticks, which keeps the exact-length low period in R6 on a known side of the threshold.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_even;
        logic       two_stop;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_FE_HOLD,
        S_MARK
    } rx_state_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_result_t;

    // index of the last data bit: 4..7
    function automatic logic [2:0] last_bit_idx(input rx_cfg_t c);
        return 3'(c.len_code) + 3'd4;
    endfunction

    // number of data bits: 5..8
    function automatic logic [3:0] data_bits(input rx_cfg_t c);
        return 4'(c.len_code) + 4'd5;
    endfunction

    // whole character length in bit times: start + data + parity + stop
    function automatic logic [3:0] frame_bits(input rx_cfg_t c);
        return 4'd1 + data_bits(c) + 4'(c.par_en) + (c.two_stop ? 4'd2 : 4'd1);
    endfunction

    // parity check over the data and the received parity bit
    function automatic logic parity_bad(input rx_cfg_t c,
                                        input logic [CHAR_W-1:0] d,
                                        input logic pbit);
        logic ones_odd;
        ones_odd = (^d) ^ pbit;
        return c.par_en && (ones_odd == c.par_even);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_break_timer.sv
module rx_break_timer
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    line,
    input  rx_cfg_t cfg,
    output logic    over
);
    localparam int CNT_MAX_I = OVS * 13;
    localparam int CW        = $clog2(CNT_MAX_I + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(CNT_MAX_I);

    logic [CW-1:0] low_cnt;
    logic [CW-1:0] limit;

    assign limit = CW'(frame_bits(cfg)) * CW'(OVS);
    assign over  = (low_cnt > limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (tick) begin
            if (line)                    low_cnt <= '0;
            else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
        end
    end

    // R6: a mark sample always returns the spacing count to zero
    p_mark_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && line) |=> (low_cnt == '0 && !over));
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  rx_cfg_t    cfg_in,
    input  logic       brk_over,
    output rx_cfg_t    cfg_q,
    output logic       emit,
    output rx_result_t res
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST_OS = CW'(OVS - 1);
    localparam logic [CW-1:0] MID_OS  = CW'(OVS / 2 - 1);

    rx_state_t         state;
    logic [CW-1:0]     os_cnt;
    logic [2:0]        bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_bit;
    logic              at_end;
    logic              perr_now;

    assign at_end   = (os_cnt == LAST_OS);
    assign perr_now = parity_bad(cfg_q, shreg, par_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            cfg_q   <= '0;
            emit    <= 1'b0;
            res     <= '0;
        end else begin
            emit <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (!line) begin
                            state   <= S_START;
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            shreg   <= '0;
                            par_bit <= 1'b0;
                            cfg_q   <= cfg_in;
                        end
                    end
                    S_START: begin
                        if (os_cnt == MID_OS) begin
                            os_cnt <= '0;
                            state  <= line ? S_IDLE : S_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (at_end) begin
                            os_cnt         <= '0;
                            shreg[bit_idx] <= line;
                            if (bit_idx == last_bit_idx(cfg_q))
                                state <= cfg_q.par_en ? S_PAR : S_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (at_end) begin
                            os_cnt  <= '0;
                            par_bit <= line;
                            state   <= S_STOP;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (at_end) begin
                            os_cnt <= '0;
                            if (line) begin
                                emit  <= 1'b1;
                                res   <= '{data: shreg, perr: perr_now,
                                           ferr: 1'b0, brk: 1'b0};
                                state <= S_IDLE;
                            end else begin
                                state <= S_FE_HOLD;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    S_FE_HOLD: begin
                        if (line) begin
                            emit  <= 1'b1;
                            res   <= '{data: shreg, perr: perr_now,
                                       ferr: 1'b1, brk: 1'b0};
                            state <= S_IDLE;
                        end else if (brk_over) begin
                            emit  <= 1'b1;
                            res   <= '{data: '0, perr: 1'b0,
                                       ferr: 1'b1, brk: 1'b1};
                            state <= S_MARK;
                        end
                    end
                    S_MARK: begin
                        if (line) state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R8: the completion strobe never lasts more than one cycle
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
        emit |=> !emit);

    // R6: a break character carries zero data and the framing flag
    p_break_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (emit && res.brk) |-> (res.data == '0 && res.ferr));

    // R4: no parity error can be reported for a frame without parity
    p_no_par_err_r4: assert property (@(posedge clk) disable iff (rst)
        (emit && !cfg_q.par_en) |-> !res.perr);

    // R3: bits above the selected length are zero
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        emit |-> ((res.data >> data_bits(cfg_q)) == '0));

    // R6: after a break only a return to mark leaves the wait state
    p_mark_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_MARK) |=> (state == S_MARK || state == S_IDLE));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_two_stop,
    output logic [7:0] rx_data,
    output logic       rx_strobe,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_break
);
    logic       line_s;
    logic       brk_over;
    rx_cfg_t    cfg_live;
    rx_cfg_t    cfg_frame;
    rx_result_t res;

    assign cfg_live = '{len_code: cfg_len, par_en: cfg_par_en,
                        par_even: cfg_par_even, two_stop: cfg_two_stop};

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    rx_break_timer #(.OVS(OVS)) u_brk (
        .clk  (clk),
        .rst  (rst),
        .tick (os_tick),
        .line (line_s),
        .cfg  (cfg_frame),
        .over (brk_over)
    );

    rx_frame_engine #(.OVS(OVS)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .line     (line_s),
        .cfg_in   (cfg_live),
        .brk_over (brk_over),
        .cfg_q    (cfg_frame),
        .emit     (rx_strobe),
        .res      (res)
    );

    assign rx_data  = res.data;
    assign rx_perr  = res.perr;
    assign rx_ferr  = res.ferr;
    assign rx_break = res.brk;
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_strobe;
    logic       rx_perr;
    logic       rx_ferr;
    logic       rx_break;

    int n_chk = 0;
    int n_fail = 0;
    int tick_div = 1;
    int tick_ph = 0;
    int cyc = 0;
    int got_cnt = 0;
    logic [7:0] got_q [0:7];
    logic [7:0] last_data;
    logic last_perr, last_ferr, last_brk;

    serial_rx_core u_dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
        .rx_data(rx_data), .rx_strobe(rx_strobe), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_break(rx_break)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick generator, changes away from the active edge
    always @(negedge clk) begin
        if (tick_ph + 1 >= tick_div) tick_ph = 0;
        else tick_ph = tick_ph + 1;
        os_tick = (tick_ph == 0);
    end

    // output monitor
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst && rx_strobe) begin
            if (got_cnt < 8) got_q[got_cnt] = rx_data;
            got_cnt   = got_cnt + 1;
            last_data = rx_data;
            last_perr = rx_perr;
            last_ferr = rx_ferr;
            last_brk  = rx_break;
        end
        if (cyc > WATCHDOG) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic line_for(input logic v, input int bits);
        rxd = v;
        repeat (bits * 16 * tick_div) @(negedge clk);
    endtask

    task automatic set_cfg(input int len, input logic pen, input logic even, input logic two);
        cfg_len      = 2'(len - 5);
        cfg_par_en   = pen;
        cfg_par_even = even;
        cfg_two_stop = two;
    endtask

    task automatic send_frame(input logic [7:0] d, input int len, input logic flip_par,
                              input logic bad_stop, input int idle_bits);
        logic p;
        logic [7:0] m;
        m = d & 8'((1 << len) - 1);
        line_for(1'b0, 1);
        for (int i = 0; i < len; i++) line_for(m[i], 1);
        if (cfg_par_en) begin
            p = cfg_par_even ? (^m) : ~(^m);
            line_for(p ^ flip_par, 1);
        end
        if (bad_stop) line_for(1'b0, 1);
        else          line_for(1'b1, cfg_two_stop ? 2 : 1);
        if (idle_bits > 0) line_for(1'b1, idle_bits);
    endtask

    task automatic clear_rx;
        got_cnt = 0;
    endtask

    task automatic expect_char(input string tag, input logic [7:0] d, input logic pe,
                               input logic fe, input logic br);
        check({tag, " count"}, 32'(got_cnt), 32'd1);
        check({tag, " data"},  32'(last_data), 32'(d));
        check({tag, " perr"},  32'(last_perr), 32'(pe));
        check({tag, " ferr"},  32'(last_ferr), 32'(fe));
        check({tag, " brk"},   32'(last_brk),  32'(br));
    endtask

    task automatic t_reset;
        check("R1 strobe", 32'(rx_strobe), 32'd0);
        check("R1 data",   32'(rx_data),   32'd0);
        check("R1 flags",  32'({rx_perr, rx_ferr, rx_break}), 32'd0);
    endtask

    task automatic t_basic;
        set_cfg(8, 1'b0, 1'b0, 1'b0);
        clear_rx; send_frame(8'hA5, 8, 1'b0, 1'b0, 1);
        expect_char("R3 8N1 a5", 8'hA5, 1'b0, 1'b0, 1'b0);
        clear_rx; send_frame(8'h3C, 8, 1'b0, 1'b0, 1);
        expect_char("R8 8N1 3c", 8'h3C, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_lengths;
        for (int len = 5; len <= 7; len++) begin
            set_cfg(len, 1'b0, 1'b0, 1'b0);
            clear_rx; send_frame(8'hFF, len, 1'b0, 1'b0, 1);
            expect_char("R3 short length", 8'((1 << len) - 1), 1'b0, 1'b0, 1'b0);
        end
        set_cfg(6, 1'b0, 1'b0, 1'b0);
        clear_rx; send_frame(8'h29, 6, 1'b0, 1'b0, 1);
        expect_char("R3 6N1 lsb first", 8'h29, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_parity;
        set_cfg(7, 1'b1, 1'b1, 1'b0);
        clear_rx; send_frame(8'h53, 7, 1'b0, 1'b0, 1);
        expect_char("R4 7E1 good", 8'h53, 1'b0, 1'b0, 1'b0);
        set_cfg(7, 1'b1, 1'b0, 1'b0);
        clear_rx; send_frame(8'h53, 7, 1'b0, 1'b0, 1);
        expect_char("R4 7O1 good", 8'h53, 1'b0, 1'b0, 1'b0);
        set_cfg(8, 1'b1, 1'b1, 1'b0);
        clear_rx; send_frame(8'hC3, 8, 1'b1, 1'b0, 1);
        expect_char("R4 8E1 bad", 8'hC3, 1'b1, 1'b0, 1'b0);
        set_cfg(5, 1'b1, 1'b0, 1'b0);
        clear_rx; send_frame(8'h0B, 5, 1'b1, 1'b0, 1);
        expect_char("R4 5O1 bad", 8'h0B, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_framing;
        set_cfg(8, 1'b0, 1'b0, 1'b0);
        clear_rx; send_frame(8'h55, 8, 1'b0, 1'b1, 2);
        expect_char("R5 bad stop", 8'h55, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_glitch;
        set_cfg(8, 1'b0, 1'b0, 1'b0);
        clear_rx;
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        line_for(1'b1, 2);
        check("R2 glitch ignored", 32'(got_cnt), 32'd0);
        clear_rx; send_frame(8'h81, 8, 1'b0, 1'b0, 1);
        expect_char("R2 after glitch", 8'h81, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_break;
        set_cfg(8, 1'b0, 1'b0, 1'b0);
        clear_rx;
        line_for(1'b0, 20);
        check("R6 single break strobe while low", 32'(got_cnt), 32'd1);
        line_for(1'b1, 2);
        expect_char("R6 break", 8'h00, 1'b0, 1'b1, 1'b1);
        clear_rx; send_frame(8'h5A, 8, 1'b0, 1'b0, 1);
        expect_char("R6 after break", 8'h5A, 1'b0, 1'b0, 1'b0);
        clear_rx;
        line_for(1'b0, 10);
        line_for(1'b1, 2);
        expect_char("R6 exact length not break", 8'h00, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_threshold;
        set_cfg(8, 1'b0, 1'b0, 1'b1);
        clear_rx;
        line_for(1'b0, 11);
        line_for(1'b1, 2);
        expect_char("R7 two stop 11 bits", 8'h00, 1'b0, 1'b1, 1'b0);
        set_cfg(8, 1'b0, 1'b0, 1'b0);
        clear_rx;
        line_for(1'b0, 11);
        line_for(1'b1, 2);
        expect_char("R7 one stop 11 bits", 8'h00, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_tick_rate;
        set_cfg(8, 1'b0, 1'b0, 1'b0);
        tick_div = 2;
        line_for(1'b1, 1);
        clear_rx; send_frame(8'h96, 8, 1'b0, 1'b0, 1);
        expect_char("R9 half tick rate", 8'h96, 1'b0, 1'b0, 1'b0);
        tick_div = 1;
        line_for(1'b1, 1);
    endtask

    task automatic t_back_to_back;
        set_cfg(8, 1'b0, 1'b0, 1'b1);
        clear_rx;
        send_frame(8'h11, 8, 1'b0, 1'b0, 0);
        send_frame(8'hE7, 8, 1'b0, 1'b0, 0);
        send_frame(8'h4D, 8, 1'b0, 1'b0, 1);
        check("R10 frame count", 32'(got_cnt), 32'd3);
        check("R10 first",  32'(got_q[0]), 32'h11);
        check("R10 second", 32'(got_q[1]), 32'hE7);
        check("R10 third",  32'(got_q[2]), 32'h4D);
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        rst = 1'b0;
        line_for(1'b1, 1);
        t_basic;
        t_lengths;
        t_parity;
        t_framing;
        t_glitch;
        t_break;
        t_threshold;
        t_tick_rate;
        t_back_to_back;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule